// File: doc/BRIEF.md
# Word-Interleaved Line-Fill Memory

This block is a word-addressed memory spread across several independent banks, four by default, with a one-word path on both the request and the return side. The two lowest bits of a word address select the bank and the bits above them select the row inside that bank. Consecutive words therefore sit in consecutive banks.

A line read starts every bank in the same cycle, using a single address transfer. The access latencies overlap, so the whole line costs one address cycle, one bank access time and one cycle per word. Four words with a six-cycle access take eleven cycles rather than four full accesses. A return sequencer then streams the words out in ascending order, one per cycle. A single-word write starts only the addressed bank.

The block accepts one request at a time. Its ready output stays low from acceptance until the operation has finished.

Top module: `ilv_mem`

## Requirements
- R1: A word write starts only the bank given by the word address modulo the bank count (the two low address bits with four banks). After it, every other word keeps its value.
- R2: The row inside a bank is the word address shifted right by log2 of the bank count. Two addresses that share a bank but differ in the upper bits hold separate words.
- R3: A line read ignores the low two bits of the request address. It returns the four words of the aligned line in ascending word order, word 0 first.
- R4: If a line read is accepted at clock edge A, word k (k = 0..3) is presented between edges A+6+k and A+7+k. Together with the request cycle, a full line spans 11 cycles.
- R5: During a line read, rsp_valid is high for exactly four consecutive cycles. rsp_last is high only together with the fourth word.
- R6: req_ready is low from the acceptance edge until the last word has been presented, and high again in the cycle after it. That allows a back-to-back line read to be accepted at edge A+11.
- R7: If a write is accepted at edge A, wr_done is high for exactly one cycle, between edges A+6 and A+7. rsp_valid stays low, and req_ready returns high after edge A+7.
- R8: While reset is high and in the cycle after it is released, req_ready is 1 and rsp_valid, rsp_last and wr_done are 0. A reset in the middle of a line read abandons it and leaves the block ready.
- R9: A request presented while req_ready is low is neither accepted nor executed. A write offered during a line read leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = single-word write, 0 = line read |
| req_addr | input | ADDR_W | Word address (line reads ignore the low log2(NUM_BANKS) bits) |
| req_wdata | input | WORD_W | Write data |
| req_ready | output | 1 | Block idle; a request is taken on a clock edge where both req_valid and req_ready are high |
| rsp_valid | output | 1 | rsp_data holds a line word |
| rsp_last | output | 1 | Current word is the last of the line |
| rsp_data | output | WORD_W | Returned word |
| wr_done | output | 1 | One-cycle write completion |

## Verification
The whole memory is first filled with address-dependent values. Line reads are then issued at aligned addresses, at addresses with nonzero low bits and at the top of the address space, all back to back. This separates a correct bank mapping from a swapped or offset one, and a correct word order from a rotated one, and it checks that ready reopens in time for the next request.

Writes to two addresses that share a bank but differ in row, followed by reads of both lines, show that only one bank and one row were touched. A write offered in the middle of a line fill, then a re-read of that line, shows that busy-time requests are dropped. A reset issued in the middle of a line fill shows that the block returns to idle and still serves the next request.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Return sequencer modes
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_LINE  = 2'd1,
        FS_WRITE = 2'd2
    } fill_state_t;

    // Per-bank launch command
    typedef struct packed {
        logic start;
        logic wr;
    } bank_cmd_t;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int ROW_W   = 6,
    parameter int ACC_LAT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_cmd_t         cmd,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    input  logic              take,
    output logic              done,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;
    localparam int CNT_W = $clog2(ACC_LAT + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;
    logic [CNT_W-1:0]  cnt;
    logic              busy;

    // Storage array: write or capture on launch
    always_ff @(posedge clk) begin
        if (cmd.start) begin
            if (cmd.wr) mem[row] <= wdata;
            else        rd_q     <= mem[row];
        end
    end

    // Fixed-latency occupancy counter
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (cmd.start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(ACC_LAT);
        end else if (busy) begin
            if (cnt != '0)  cnt  <= cnt - 1'b1;
            else if (take)  busy <= 1'b0;
        end
    end

    assign done  = busy && (cnt == '0);
    assign rdata = rd_q;
endmodule

// File: rtl/ilv_return_seq.sv
module ilv_return_seq
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WORD_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              line_go,
    input  logic                              write_go,
    input  logic [$clog2(NUM_BANKS)-1:0]      write_bank,
    input  logic [NUM_BANKS-1:0]              bank_done,
    input  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_rdata,
    output logic [NUM_BANKS-1:0]              bank_take,
    output logic                              busy,
    output logic                              rsp_valid,
    output logic                              rsp_last,
    output logic [WORD_W-1:0]                 rsp_data,
    output logic                              wr_done
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    fill_state_t       state;
    logic [BANK_W-1:0] idx;
    logic [BANK_W-1:0] wr_bank_q;

    assign busy      = (state != FS_IDLE);
    assign rsp_valid = (state == FS_LINE) && bank_done[idx];
    assign rsp_last  = rsp_valid && (idx == BANK_W'(NUM_BANKS - 1));
    assign rsp_data  = bank_rdata[idx];
    assign wr_done   = (state == FS_WRITE) && bank_done[wr_bank_q];

    always_comb begin
        bank_take = '0;
        if (rsp_valid) bank_take[idx]       = 1'b1;
        if (wr_done)   bank_take[wr_bank_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FS_IDLE;
            idx       <= '0;
            wr_bank_q <= '0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (line_go) begin
                        state <= FS_LINE;
                        idx   <= '0;
                    end else if (write_go) begin
                        state     <= FS_WRITE;
                        wr_bank_q <= write_bank;
                    end
                end
                FS_LINE: begin
                    if (rsp_valid) begin
                        idx <= idx + 1'b1;
                        if (rsp_last) state <= FS_IDLE;
                    end
                end
                FS_WRITE: begin
                    if (wr_done) state <= FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int ACC_LAT   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [WORD_W-1:0] rsp_data,
    output logic              wr_done
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    logic                             seq_busy;
    logic                             accept;
    logic [BANK_W-1:0]                bank_sel;
    logic [ROW_W-1:0]                 row_sel;
    logic [NUM_BANKS-1:0]             bank_start_vec;
    logic [NUM_BANKS-1:0]             bank_done;
    logic [NUM_BANKS-1:0]             bank_take;
    logic [NUM_BANKS-1:0][WORD_W-1:0] bank_rdata;

    assign req_ready = !seq_busy;
    assign accept    = req_valid && !seq_busy;
    assign bank_sel  = req_addr[BANK_W-1:0];
    assign row_sel   = req_addr[ADDR_W-1:BANK_W];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_cmd_t cmd;
        assign cmd.start = accept && (!req_write || (bank_sel == BANK_W'(b)));
        assign cmd.wr    = req_write;
        assign bank_start_vec[b] = cmd.start;

        ilv_bank #(
            .WORD_W (WORD_W),
            .ROW_W  (ROW_W),
            .ACC_LAT(ACC_LAT)
        ) u_bank (
            .clk  (clk),
            .rst  (rst),
            .cmd  (cmd),
            .row  (row_sel),
            .wdata(req_wdata),
            .take (bank_take[b]),
            .done (bank_done[b]),
            .rdata(bank_rdata[b])
        );
    end

    ilv_return_seq #(
        .NUM_BANKS(NUM_BANKS),
        .WORD_W   (WORD_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .line_go   (accept && !req_write),
        .write_go  (accept && req_write),
        .write_bank(bank_sel),
        .bank_done (bank_done),
        .bank_rdata(bank_rdata),
        .bank_take (bank_take),
        .busy      (seq_busy),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last),
        .rsp_data  (rsp_data),
        .wr_done   (wr_done)
    );
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ACC_LAT   = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic                 rsp_last,
    input logic                 wr_done,
    input logic [NUM_BANKS-1:0] bank_start
);
    localparam logic [7:0] LAT8 = 8'(ACC_LAT);

    logic       line_act;
    logic [7:0] since;

    // Cycles elapsed since a line read was accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            line_act <= 1'b0;
            since    <= '0;
        end else if (req_valid && req_ready && !req_write) begin
            line_act <= 1'b1;
            since    <= '0;
        end else if (rsp_last) begin
            line_act <= 1'b0;
        end else if (line_act && since != 8'hFF) begin
            since <= since + 1'b1;
        end
    end

    a_r1_write_one_bank: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |-> ($countones(bank_start) == 1));
    a_r3_line_all_banks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |-> (&bank_start));
    a_r4_quiet_before_lat: assert property (@(posedge clk) disable iff (rst)
        (line_act && since < LAT8) |-> !rsp_valid);
    a_r4_first_word_on_time: assert property (@(posedge clk) disable iff (rst)
        (line_act && since == LAT8) |-> rsp_valid);
    a_r5_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);
    a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_last) |=> rsp_valid);
    a_r6_busy_streaming: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);
    a_r6_ready_after_last: assert property (@(posedge clk) disable iff (rst)
        rsp_last |=> req_ready);
    a_r7_done_not_stream: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> !rsp_valid);
    a_r7_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> (req_ready && !wr_done));
    a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (bank_start == '0));
endmodule

bind ilv_mem ilv_mem_chk #(
    .NUM_BANKS(NUM_BANKS),
    .ACC_LAT  (ACC_LAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .wr_done   (wr_done),
    .bank_start(bank_start_vec)
);

// File: tb/sim_ilv_mem.sv
`timescale 1ns/1ps
module sim_ilv_mem;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NW = 1 << AW;

    // Line-read stimulus table: request address (expected words come from the model)
    localparam logic [7:0] LINE_TAB [8] = '{8'h00, 8'h07, 8'h13, 8'h3C,
                                            8'h42, 8'h81, 8'hFE, 8'hC9};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_last, wr_done;
    logic [DW-1:0] rsp_data;

    logic [DW-1:0] model [NW];
    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    ilv_mem u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_data(rsp_data),
        .wr_done(wr_done)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // Write one word; inputs change on falling edges only
    task automatic write_word(input logic [7:0] a, input logic [31:0] d);
        logic bad;
        logic [31:0] bad_act, bad_exp;
        bad = 1'b0; bad_act = '0; bad_exp = '0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (req_ready !== 1'b0) begin
            bad = 1'b1; bad_act = {31'd0, req_ready}; bad_exp = 32'd0;
        end
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (!bad && ({wr_done, req_ready, rsp_valid} !== {k == 6, k == 7, 1'b0})) begin
                bad = 1'b1;
                bad_act = {k[15:0], 13'd0, wr_done, req_ready, rsp_valid};
                bad_exp = {k[15:0], 13'd0, k == 6, k == 7, 1'b0};
            end
        end
        model[a] = d;
        check(!bad, "R7", "write timing {k,done,ready,valid}", bad_act, bad_exp);
    endtask

    // Line read with optional write offered while busy (inj_k = 0: none)
    task automatic read_line(input logic [7:0] a, input int inj_k,
                             input logic [7:0] inj_a, input logic [31:0] inj_d);
        logic [7:0]  base;
        logic [31:0] got [4];
        logic bad;
        logic [31:0] bad_act, bad_exp;
        base = a & 8'hFC;
        bad = 1'b0; bad_act = '0; bad_exp = '0;
        for (int w = 0; w < 4; w++) got[w] = 'x;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R6", "ready after accept", {31'd0, req_ready}, 32'd0);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k >= 6 && k <= 9 && rsp_valid === 1'b1) got[k-6] = rsp_data;
            if (!bad && ({rsp_valid, rsp_last, req_ready} !==
                         {k >= 6 && k <= 9, k == 9, k == 10})) begin
                bad = 1'b1;
                bad_act = {k[15:0], 13'd0, rsp_valid, rsp_last, req_ready};
                bad_exp = {k[15:0], 13'd0, k >= 6 && k <= 9, k == 9, k == 10};
            end
            req_valid = (k == inj_k);
            if (k == inj_k) begin
                req_write = 1'b1; req_addr = inj_a; req_wdata = inj_d;
            end
        end
        req_valid = 1'b0; req_write = 1'b0;
        check(!bad, "R4/R5", "line timing {k,valid,last,ready}", bad_act, bad_exp);
        for (int w = 0; w < 4; w++)
            check(got[w] === model[base + 8'(w)], "R3", $sformatf("word %0d of line %h", w, base),
                  got[w], model[base + 8'(w)]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check({req_ready, rsp_valid, rsp_last, wr_done} === 4'b1000, "R8", "outputs in reset",
              {28'd0, req_ready, rsp_valid, rsp_last, wr_done}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        check({req_ready, rsp_valid, rsp_last, wr_done} === 4'b1000, "R8", "outputs after reset",
              {28'd0, req_ready, rsp_valid, rsp_last, wr_done}, 32'h8);

        // Preload every word with an address-dependent value
        for (int a = 0; a < NW; a++)
            write_word(8'(a), 32'h5A00_0000 ^ (32'(a) * 32'h0001_0101));

        // Table walk: back-to-back line reads (R3, R4, R5, R6)
        for (int i = 0; i < 8; i++)
            read_line(LINE_TAB[i], 0, 8'h00, 32'h0);

        // R1, R2: same bank, different rows; only the written word changes
        write_word(8'h45, 32'hCAFE_0045);
        write_word(8'h05, 32'hBEEF_0005);
        read_line(8'h44, 0, 8'h00, 32'h0);
        read_line(8'h06, 0, 8'h00, 32'h0);
        check(model[8'h44] === (32'h5A00_0000 ^ (32'h44 * 32'h0001_0101)), "R1",
              "neighbour word model untouched", model[8'h44], 32'h5A00_0000 ^ (32'h44 * 32'h0001_0101));

        // R9: write offered during a line read must be dropped
        read_line(8'h20, 2, 8'h21, 32'hDEAD_DEAD);
        read_line(8'h21, 0, 8'h00, 32'h0);
        check(model[8'h21] !== 32'hDEAD_DEAD, "R9", "model holds original", model[8'h21], 32'h0);

        // R8: reset in the middle of a line read
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h80;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({req_ready, rsp_valid, rsp_last, wr_done} === 4'b1000, "R8", "idle after mid-line reset",
              {28'd0, req_ready, rsp_valid, rsp_last, wr_done}, 32'h8);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (rsp_valid !== 1'b0 || req_ready !== 1'b1)
                check(1'b0, "R8", "stray output after reset", {30'd0, rsp_valid, req_ready}, 32'h1);
        end
        read_line(8'h80, 0, 8'h00, 32'h0);

        summary();
        $finish;
    end
endmodule